// File: doc/BRIEF.md
# Fetch-Execute Program Sequencer

This block steps a processor through its instructions one at a time. It holds a program counter and an instruction register, and it alternates between two named states. In `PH_FETCH` it presents the counter on the instruction-memory address, waits for the memory's ready signal and captures the returned 32-bit word. In `PH_EXEC` it raises a one-cycle execute strobe so that an external decoder and datapath can act on the held instruction. Instructions sit one word apart, so a completed fetch moves the counter on by four bytes.

During the execute cycle the decoder presents a branch code, a signed byte offset and a "last result greater than zero" flag. A taken branch replaces the counter with the offset added to the counter that has already been incremented. A branch that is not taken leaves the counter at the next sequential word. A synchronous reset loads a start address and enters `PH_FETCH`. The state transitions are: reset → `PH_FETCH`; `PH_FETCH` stays in `PH_FETCH` while memory is not ready (`STALL`); `PH_FETCH` → `PH_EXEC` when memory is ready (`FETCH_DONE`); `PH_EXEC` → `PH_FETCH` always (`RETIRE`).

Top module: `fetch_exec_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `imem_addr` equal to `start_addr` with its two low bits cleared, `imem_req` high, `exec_strobe` low and `instr` equal to zero.
- R2: In the fetch state with `imem_rdy` low, `imem_req` stays high, `imem_addr` holds its value and `exec_strobe` stays low.
- R3: A fetch-state edge with `imem_rdy` high loads `imem_data` into `instr`. In the next cycle `exec_strobe` is high, for exactly one cycle.
- R4: A completed fetch from address A makes `pc` equal A+4 during the execute cycle.
- R5: Branch code 2'b01 (branch if greater than zero) with `res_gt_zero` high makes the next fetch address `pc` plus the sign-extended `br_offset`.
- R6: Branch code 2'b01 with `res_gt_zero` low makes the next fetch address the incremented `pc`.
- R7: Branch code 2'b10 (always) makes the next fetch address `pc` plus the sign-extended `br_offset`, whatever the value of `res_gt_zero`.
- R8: Branch codes 2'b00 (none) and 2'b11 (reserved) never branch, even with `res_gt_zero` high.
- R9: `br_code`, `br_offset` and `res_gt_zero` have no effect outside the execute cycle.
- R10: Fetch addresses are always word-aligned. The two low bits of the start address and of a computed branch target are dropped.
- R11: `instr` changes only on a completed fetch. Changes on `imem_data` at any other time are ignored.
- R12: The two phases are exclusive (`imem_req` and `exec_strobe` are never high together), and every execute cycle is followed by a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | ADDR_W | Counter value loaded at reset |
| imem_req | output | 1 | High in the fetch state |
| imem_addr | output | ADDR_W | Instruction fetch address |
| imem_rdy | input | 1 | Memory has valid data on `imem_data` |
| imem_data | input | INSTR_W | Returned instruction word |
| instr | output | INSTR_W | Instruction register |
| exec_strobe | output | 1 | One-cycle execute strobe |
| pc | output | ADDR_W | Program counter |
| br_code | input | 2 | 00 none, 01 if greater than zero, 10 always, 11 reserved |
| br_offset | input | OFF_W | Signed byte offset from the incremented counter |
| res_gt_zero | input | 1 | Last result was greater than zero |

## Verification
The properties assume that `imem_data` is valid in any cycle in which `imem_rdy` is high during a fetch. They also assume that the branch inputs are settled during the execute cycle and that reset is held for at least two edges. The bench drives every input at the falling edge, so nothing changes at a sampling edge, and it holds reset for three cycles. It also parks a large always-taken branch on the branch inputs throughout every fetch and stall. This shows that the sequencer reads those inputs only while `exec_strobe` is high.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [0:0] {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_t;

    typedef enum logic [1:0] {
        BR_NONE   = 2'b00,
        BR_IF_GT  = 2'b01,
        BR_ALWAYS = 2'b10,
        BR_RSVD   = 2'b11
    } br_code_t;

    localparam int WORD_BYTES = 4;
    localparam int ALIGN_BITS = 2;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_ok,
    output logic fetch_active,
    output logic exec_active,
    output logic ir_load,
    output logic pc_step
);
    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FETCH: state_d = fetch_ok ? PH_EXEC : PH_FETCH;
            PH_EXEC:  state_d = PH_FETCH;
        endcase
    end

    always_comb begin
        fetch_active = 1'b0;
        exec_active  = 1'b0;
        ir_load      = 1'b0;
        pc_step      = 1'b0;
        unique case (state_q)
            PH_FETCH: begin
                fetch_active = 1'b1;
                ir_load      = fetch_ok;
                pc_step      = fetch_ok;
            end
            PH_EXEC: begin
                exec_active = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/seq_branch_eval.sv
module seq_branch_eval
    import seq_pkg::*;
(
    input  logic       enable,
    input  logic [1:0] code,
    input  logic       gt_zero,
    output logic       take
);
    br_code_t kind;
    assign kind = br_code_t'(code);

    always_comb begin
        take = 1'b0;
        unique case (kind)
            BR_NONE:   take = 1'b0;
            BR_IF_GT:  take = gt_zero;
            BR_ALWAYS: take = 1'b1;
            BR_RSVD:   take = 1'b0;
        endcase
        take = take & enable;
    end
endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
    import seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              step,
    input  logic              jump,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] pc
);
    localparam int EXT_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] start_al;

    generate
        if (EXT_W > 0) begin : g_sext
            assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    assign target   = (pc + off_ext) & ALIGN_MASK;
    assign start_al = start_addr & ALIGN_MASK;

    always_ff @(posedge clk) begin
        if (rst)       pc <= start_al;
        else if (jump) pc <= target;
        else if (step) pc <= pc + STRIDE;
    end
endmodule

// File: rtl/seq_ir.sv
module seq_ir #(
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [INSTR_W-1:0] din,
    output logic [INSTR_W-1:0] ir
);
    always_ff @(posedge clk) begin
        if (rst)       ir <= '0;
        else if (load) ir <= din;
    end
endmodule

// File: rtl/fetch_exec_sequencer.sv
module fetch_exec_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INSTR_W = 32,
    parameter int OFF_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  start_addr,
    output logic               imem_req,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic               imem_rdy,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [INSTR_W-1:0] instr,
    output logic               exec_strobe,
    output logic [ADDR_W-1:0]  pc,
    input  logic [1:0]         br_code,
    input  logic [OFF_W-1:0]   br_offset,
    input  logic               res_gt_zero
);
    logic fetch_active;
    logic exec_active;
    logic ir_load;
    logic pc_step;
    logic take;

    seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fetch_ok     (imem_rdy),
        .fetch_active (fetch_active),
        .exec_active  (exec_active),
        .ir_load      (ir_load),
        .pc_step      (pc_step)
    );

    seq_branch_eval u_br (
        .enable  (exec_active),
        .code    (br_code),
        .gt_zero (res_gt_zero),
        .take    (take)
    );

    seq_pc_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .start_addr (start_addr),
        .step       (pc_step),
        .jump       (take),
        .offset     (br_offset),
        .pc         (pc)
    );

    seq_ir #(.INSTR_W(INSTR_W)) u_ir (
        .clk  (clk),
        .rst  (rst),
        .load (ir_load),
        .din  (imem_data),
        .ir   (instr)
    );

    assign imem_req    = fetch_active;
    assign imem_addr   = pc;
    assign exec_strobe = exec_active;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int ADDR_W  = 32,
    parameter int INSTR_W = 32,
    parameter int OFF_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  start_addr,
    input logic               imem_req,
    input logic [ADDR_W-1:0]  imem_addr,
    input logic               imem_rdy,
    input logic [INSTR_W-1:0] imem_data,
    input logic [INSTR_W-1:0] instr,
    input logic               exec_strobe,
    input logic [ADDR_W-1:0]  pc,
    input logic [1:0]         br_code,
    input logic [OFF_W-1:0]   br_offset,
    input logic               res_gt_zero
);
    localparam logic [ADDR_W-1:0] LOW2 = ADDR_W'(3);
    logic [ADDR_W-1:0] off_x;
    assign off_x = ADDR_W'($signed(br_offset));

    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == ($past(start_addr) & ~LOW2)) && imem_req && !exec_strobe);

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (imem_req && !imem_rdy) |=> imem_req && $stable(imem_addr) && !exec_strobe);

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (imem_req && imem_rdy) |=> exec_strobe && (instr == $past(imem_data)));

    p_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (imem_req && imem_rdy) |=> (pc == $past(imem_addr) + ADDR_W'(4)));

    p_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (exec_strobe && (br_code == 2'b10 || (br_code == 2'b01 && res_gt_zero)))
        |=> (imem_addr == (($past(pc) + $past(off_x)) & ~LOW2)));

    p_fallthru_r8: assert property (@(posedge clk) disable iff (rst)
        (exec_strobe && (br_code == 2'b00 || br_code == 2'b11 || (br_code == 2'b01 && !res_gt_zero)))
        |=> (imem_addr == $past(pc)));

    p_aligned_r10: assert property (@(posedge clk) disable iff (rst)
        (imem_addr & LOW2) == '0);

    p_ir_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(imem_req && imem_rdy) |=> $stable(instr));

    p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        !(imem_req && exec_strobe));

    p_retire_r12: assert property (@(posedge clk) disable iff (rst)
        exec_strobe |=> imem_req && !exec_strobe);
endmodule

bind fetch_exec_sequencer seq_checker #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_addr  (start_addr),
    .imem_req    (imem_req),
    .imem_addr   (imem_addr),
    .imem_rdy    (imem_rdy),
    .imem_data   (imem_data),
    .instr       (instr),
    .exec_strobe (exec_strobe),
    .pc          (pc),
    .br_code     (br_code),
    .br_offset   (br_offset),
    .res_gt_zero (res_gt_zero)
);

// File: tb/fetch_exec_sequencer_bench.sv
module fetch_exec_sequencer_bench;
    localparam int ADDR_W  = 32;
    localparam int INSTR_W = 32;
    localparam int OFF_W   = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [ADDR_W-1:0]  start_addr = '0;
    logic               imem_req;
    logic [ADDR_W-1:0]  imem_addr;
    logic               imem_rdy = 1'b0;
    logic [INSTR_W-1:0] imem_data = '0;
    logic [INSTR_W-1:0] instr;
    logic               exec_strobe;
    logic [ADDR_W-1:0]  pc;
    logic [1:0]         br_code = 2'b00;
    logic [OFF_W-1:0]   br_offset = '0;
    logic               res_gt_zero = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] cur;
    logic [31:0] last_word;

    always #4 clk = ~clk;

    fetch_exec_sequencer #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W)) u_fetch_exec_sequencer (
        .clk(clk), .rst(rst), .start_addr(start_addr),
        .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdy(imem_rdy),
        .imem_data(imem_data), .instr(instr), .exec_strobe(exec_strobe),
        .pc(pc), .br_code(br_code), .br_offset(br_offset), .res_gt_zero(res_gt_zero)
    );

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Park a large always-taken branch on the branch inputs (must be ignored, R9).
    task automatic park_branch();
        br_code = 2'b10; br_offset = 16'h0400; res_gt_zero = 1'b1;
    endtask

    task automatic t_reset(input logic [31:0] sa);
        rst = 1'b1; start_addr = sa; imem_rdy = 1'b0; park_branch();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur = sa & ~32'h3;
        chk_eq("R1", "reset addr", imem_addr, cur);
        chk_eq("R10", "reset addr low bits", {30'd0, imem_addr[1:0]}, 32'd0);
        chk_eq("R1", "reset req", {31'd0, imem_req}, 32'd1);
        chk_eq("R1", "reset strobe", {31'd0, exec_strobe}, 32'd0);
        chk_eq("R1", "reset instr", instr, 32'd0);
        last_word = 32'd0;
    endtask

    task automatic fetch_step(input logic [31:0] word, input int stall);
        for (int k = 0; k < stall; k++) begin
            chk_eq("R2", "stall req", {31'd0, imem_req}, 32'd1);
            chk_eq("R9", "stall addr", imem_addr, cur);
            chk_eq("R2", "stall strobe", {31'd0, exec_strobe}, 32'd0);
            chk_eq("R11", "stall instr", instr, last_word);
            imem_rdy = 1'b0; imem_data = 32'hBAD0_0000 + k; park_branch();
            @(negedge clk);
        end
        chk_eq("R12", "fetch req", {31'd0, imem_req}, 32'd1);
        chk_eq("R2", "fetch addr", imem_addr, cur);
        imem_rdy = 1'b1; imem_data = word; park_branch();
        @(negedge clk);
        imem_rdy = 1'b0; imem_data = ~word;
        chk_eq("R3", "exec strobe", {31'd0, exec_strobe}, 32'd1);
        chk_eq("R3", "instr capture", instr, word);
        chk_eq("R4", "pc advance", pc, cur + 32'd4);
        chk_eq("R12", "req low in exec", {31'd0, imem_req}, 32'd0);
        last_word = word;
    endtask

    task automatic exec_step(input logic [1:0] code, input logic [15:0] off,
                             input bit gt, input string req);
        logic [31:0] base;
        logic [31:0] nxt;
        bit taken;
        base  = cur + 32'd4;
        taken = (code == 2'b10) || (code == 2'b01 && gt);
        nxt   = taken ? ((base + {{16{off[15]}}, off}) & ~32'h3) : base;
        br_code = code; br_offset = off; res_gt_zero = gt;
        @(negedge clk);
        park_branch();
        chk_eq(req, "next fetch addr", imem_addr, nxt);
        chk_eq("R12", "back to fetch", {31'd0, imem_req}, 32'd1);
        chk_eq("R3", "strobe one cycle", {31'd0, exec_strobe}, 32'd0);
        chk_eq("R11", "instr held", instr, last_word);
        cur = nxt;
    endtask

    task automatic t_straight();
        fetch_step(32'h1111_0001, 0); exec_step(2'b00, 16'h0000, 1'b0, "R4");
        fetch_step(32'h1111_0002, 0); exec_step(2'b00, 16'h0000, 1'b0, "R4");
        fetch_step(32'h1111_0003, 0); exec_step(2'b00, 16'h0000, 1'b0, "R4");
        chk_eq("R4", "three words on", cur, 32'd1012);
    endtask

    task automatic t_loop_back();
        fetch_step(32'h2222_0001, 1);
        exec_step(2'b01, 16'hFFF0, 1'b1, "R5");
        chk_eq("R5", "loop target", cur, 32'd1000);
    endtask

    task automatic t_not_taken();
        fetch_step(32'h3333_0001, 0);
        exec_step(2'b01, 16'hFFF0, 1'b0, "R6");
    endtask

    task automatic t_always();
        fetch_step(32'h4444_0001, 0);
        exec_step(2'b10, 16'h0040, 1'b0, "R7");
        fetch_step(32'h4444_0002, 0);
        exec_step(2'b10, 16'hFFE0, 1'b1, "R7");
    endtask

    task automatic t_no_branch_codes();
        fetch_step(32'h5555_0001, 0);
        exec_step(2'b00, 16'h0100, 1'b1, "R8");
        fetch_step(32'h5555_0002, 0);
        exec_step(2'b11, 16'h0100, 1'b1, "R8");
    endtask

    task automatic t_stall_ignore();
        fetch_step(32'h6666_0001, 3);
        exec_step(2'b00, 16'h0000, 1'b1, "R9");
    endtask

    task automatic t_misaligned();
        fetch_step(32'h7777_0001, 0);
        exec_step(2'b10, 16'h000A, 1'b0, "R10");
        chk_eq("R10", "target low bits", {30'd0, imem_addr[1:0]}, 32'd0);
    endtask

    task automatic t_reset_midstream();
        fetch_step(32'h8888_0001, 0);
        t_reset(32'h0000_2003);
        fetch_step(32'h8888_0002, 0);
        exec_step(2'b00, 16'h0000, 1'b0, "R1");
    endtask

    initial begin
        t_reset(32'd1003);
        t_straight();
        t_loop_back();
        t_not_taken();
        t_always();
        t_no_branch_codes();
        t_stall_ignore();
        t_misaligned();
        t_reset_midstream();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule